// File: doc/BRIEF.md
# Selectable Decade Gate Timebase

This block produces the counting window for a frequency meter. A reference tick at 1 kHz (one tick per millisecond, arriving as a single-cycle enable in the system clock domain) feeds a chain of divide-by-ten stages. The stages give 10 ms, 100 ms and 1 s timing, and the tick itself gives 1 ms. A two-bit range input picks one of these four as the window width T.

The output `gate` is a square wave. It is high for T and low for T, so its period is 2T. A pulse counter runs only while `gate` is high. The low half leaves time to latch the result and clear the counter. On the first cycle of each low half, `gate_end` pulses for one clock. A change of range is taken up only when a new window opens, so a window in progress is never cut short. Both halves are measured in whole reference ticks, and both are restarted from zero by a synchronous reset.

Top module: `decade_gate_timebase`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `gate` = 0 and `gate_end` = 0.
- R2: With `range_sel` = 2'b00, each high half of `gate` spans exactly 1000 ticks.
- R3: With `range_sel` = 2'b01, each high half of `gate` spans exactly 100 ticks.
- R4: With `range_sel` = 2'b10, each high half of `gate` spans exactly 10 ticks.
- R5: With `range_sel` = 2'b11, each high half of `gate` spans exactly 1 tick.
- R6: Each low half lasts the same number of ticks as the high half before it. After reset, the first low half uses the width selected while reset was held.
- R7: The width is sampled from `range_sel` only on the clock edge where `gate` rises. A change during a window does not alter that window or the low half after it. The change applies to the next window.
- R8: `gate_end` is high for exactly one cycle, the first cycle in which `gate` reads 0 after having been 1. It is low at all other times.
- R9: Clock cycles without `tick` do not advance the timing. `gate` holds its value through any run of tick-free cycles, and the window still spans exactly T ticks.
- R10: A reset asserted in the middle of a window ends it at once. After release, the first low half lasts a full T of the newly selected width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | 1 kHz reference enable, one clock wide |
| range_sel | input | 2 | Width select: 00 = 1 s, 01 = 100 ms, 10 = 10 ms, 11 = 1 ms |
| gate | output | 1 | Window output, high while counting is allowed |
| gate_end | output | 1 | One-cycle strobe on the first low cycle of each window end |

## Verification
The bench builds the block with its default decade radix and three stages, so every width in the requirements is produced by real cascade carries. This includes the full 1000-tick window, where all three stages roll over together. Ticks arrive every third clock, which leaves tick-free cycles between every pair of ticks. A range change inside a window and a reset inside a window are both driven, so the carry chain is seen to restart cleanly from a partial count.

// File: rtl/decade_gate_timebase.sv
module decade_gate_timebase #(
  parameter int RADIX  = 10,
  parameter int STAGES = 3,
  localparam int CW = $clog2(RADIX),
  localparam int SW = $clog2(STAGES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [SW-1:0] range_sel,
  output logic          gate,
  output logic          gate_end
);

  localparam logic [CW-1:0] TOP = CW'(RADIX - 1);

  logic [CW-1:0] cnt [STAGES];
  logic [STAGES:0] full;
  logic [SW-1:0] act_sel;
  logic tap;
  logic phase_done;

  assign full[0] = 1'b1;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    assign full[k+1] = full[k] && (cnt[k] == TOP);

    always_ff @(posedge clk) begin
      if (rst || phase_done)
        cnt[k] <= '0;
      else if (tick && full[k])
        cnt[k] <= (cnt[k] == TOP) ? '0 : cnt[k] + 1'b1;
    end
  end

  always_comb begin
    tap = full[0];
    for (int s = 0; s <= STAGES; s++)
      if (act_sel == SW'(s)) tap = full[STAGES - s];
  end

  assign phase_done = tick && tap;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate     <= 1'b0;
      gate_end <= 1'b0;
      act_sel  <= range_sel;
    end else begin
      gate_end <= phase_done && gate;
      if (phase_done) begin
        gate <= ~gate;
        if (!gate) act_sel <= range_sel;
      end
    end
  end

endmodule

// File: rtl/decade_gate_timebase_chk.sv
module decade_gate_timebase_chk #(
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          gate,
  input logic          gate_end,
  input logic [SW-1:0] act_sel
);

  p_reset_low_r1: assert property (@(posedge clk) rst |=> (!gate && !gate_end));

  p_end_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
    gate_end |-> ($past(gate) && !gate));

  p_fall_gives_end_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(gate) && !$past(rst)) |-> gate_end);

  p_end_single_r8: assert property (@(posedge clk) disable iff (rst)
    gate_end |=> !gate_end);

  p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick) && !$past(rst)) |-> $stable(gate));

  p_sel_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (!$rose(gate) && !$past(rst)) |-> $stable(act_sel));

endmodule

bind decade_gate_timebase decade_gate_timebase_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .gate(gate), .gate_end(gate_end), .act_sel(act_sel)
);

// File: tb/decade_gate_timebase_bench.sv
module decade_gate_timebase_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 3;

  logic clk = 0, rst = 1, tick = 0, tick_en = 1;
  logic [1:0] range_sel = 2'b00;
  logic gate, gate_end;

  int checks = 0, errors = 0;
  int run = 0, done_hi = 0, done_lo = 0, n_hi = 0, n_lo = 0;
  logic prev_g = 0;

  decade_gate_timebase u_decade_gate_timebase (
    .clk(clk), .rst(rst), .tick(tick), .range_sel(range_sel),
    .gate(gate), .gate_end(gate_end)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      tick = tick_en && (div == TDIV - 1);
      div = (div + 1) % TDIV;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst) begin
        run = 0; prev_g = 0;
      end else begin
        if (gate_end != (prev_g && !gate)) chk(0, "R8 gate_end", gate_end, prev_g && !gate);
        if (gate != prev_g) begin
          if (prev_g) begin
            done_hi = run; n_hi++;
            chk(gate_end == 1'b1, "R8 strobe at fall", gate_end, 1);
          end else begin
            done_lo = run; n_lo++;
          end
          run = 0;
        end
        if (tick) run++;
        prev_g = gate;
      end
    end
  end

  task automatic do_reset(input logic [1:0] sel);
    range_sel = sel;
    @(negedge clk); rst = 1;
    repeat (4) @(negedge clk);
    #1 chk(gate == 0 && gate_end == 0, "R1 reset state", {gate, gate_end}, 0);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_width(input logic [1:0] sel, input int t, input string req);
    int h, l;
    do_reset(sel);
    l = n_lo; wait (n_lo == l + 1);
    chk(done_lo == t, "R6 first low after reset", done_lo, t);
    h = n_hi; wait (n_hi == h + 1);
    chk(done_hi == t, req, done_hi, t);
    l = n_lo; wait (n_lo == l + 1);
    chk(done_lo == t, "R6 low equals high", done_lo, t);
  endtask

  task automatic t_change_mid_window;
    int h, l;
    do_reset(2'b10);
    l = n_lo; wait (n_lo == l + 1);
    repeat (12) @(negedge clk);
    range_sel = 2'b01;
    h = n_hi; wait (n_hi == h + 1);
    chk(done_hi == 10, "R7 window kept", done_hi, 10);
    l = n_lo; wait (n_lo == l + 1);
    chk(done_lo == 10, "R7 low kept", done_lo, 10);
    h = n_hi; wait (n_hi == h + 1);
    chk(done_hi == 100, "R7 next window new width", done_hi, 100);
  endtask

  task automatic t_no_tick;
    int h, l;
    do_reset(2'b10);
    l = n_lo; wait (n_lo == l + 1);
    repeat (9) @(negedge clk);
    tick_en = 0;
    repeat (200) @(negedge clk);
    #1 chk(gate == 1'b1, "R9 gate held without tick", gate, 1);
    tick_en = 1;
    h = n_hi; wait (n_hi == h + 1);
    chk(done_hi == 10, "R9 width intact", done_hi, 10);
  endtask

  task automatic t_reset_mid;
    int l;
    do_reset(2'b01);
    l = n_lo; wait (n_lo == l + 1);
    repeat (60) @(negedge clk);
    do_reset(2'b10);
    l = n_lo; wait (n_lo == l + 1);
    chk(done_lo == 10, "R10 restart low width", done_lo, 10);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_width(2'b11, 1, "R5 1-tick window");
    t_width(2'b10, 10, "R4 10-tick window");
    t_width(2'b01, 100, "R3 100-tick window");
    t_width(2'b00, 1000, "R2 1000-tick window");
    t_change_mid_window();
    t_no_tick();
    t_reset_mid();
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule